// File: doc/BRIEF.md
# Asymmetric Duty Clock Prescaler

This block derives a slow conversion clock from the system clock. The high phase and the low phase of the derived clock are each set by their own count field, so the duty cycle is a free choice rather than a fixed ratio. A phase lasts its field value plus one system clock cycle. The block also gives a one-cycle strobe in the system clock domain on every rising edge of the derived clock, so downstream logic can act on that edge without treating the derived clock as a clock.

The block counts system cycles within the current phase. When the count reaches the limit for that phase, the block toggles the output and loads the limit for the next phase from the matching field. A field is therefore read only at the start of a phase. A write that lands mid-phase never shortens or stretches the phase already running. Reset or a low enable parks the output low and clears the phase counter. When the block resumes, it always begins with a low phase.

Top module: `asym_clk_prescaler`

## Requirements
- R1: While enabled, every high phase of `clk_div` lasts exactly `hi_cnt + 1` system cycles (field range 0 to 31), using the `hi_cnt` value present on the clock edge where the output rose.
- R2: While enabled, every low phase of `clk_div` that follows a high phase lasts exactly `lo_cnt + 1` system cycles (field range 0 to 7), using the `lo_cnt` value present on the clock edge where the output fell.
- R3: The field pairs (19, 7), (11, 7) and (7, 7) give rise-to-rise periods of 28, 20 and 16 cycles, and the pair (7, 7) gives a high phase of 8 cycles.
- R4: A change to `hi_cnt` or `lo_cnt` during a phase does not alter that phase. The new value is used from the next phase of the same kind.
- R5: `rise_stb` is high for exactly one system cycle: the first cycle in which `clk_div` is high after being low. It is low in every other cycle.
- R6: One cycle after a clock edge that samples `en` low, `clk_div` and `rise_stb` are low. After `en` returns high, `clk_div` first rises on the (`lo_cnt` + 1)-th rising edge that samples `en` high.
- R7: While `rst_n` is low, `clk_div` and `rise_stb` are low. After release with `en` high, the first rise occurs on the (`lo_cnt` + 1)-th edge, as in R6.
- R8: The extreme settings are supported. Fields (0, 0) toggle `clk_div` on every cycle, with a period of 2. Fields (31, 7) give a period of 40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable. Low parks the output low |
| hi_cnt | input | HI_W (5) | High phase length minus one |
| lo_cnt | input | LO_W (3) | Low phase length minus one |
| clk_div | output | 1 | Derived clock |
| rise_stb | output | 1 | One-cycle strobe on each rising edge of clk_div |

## Verification
Both outputs are registered. Any effect of an edge that samples the fields, `en` or `rst_n` therefore appears in the cycle right after that edge. The bench samples on the falling edge, before it drives new inputs. This way, the input values it reads at a sample are exactly the ones the preceding rising edge consumed. Each phase length is checked when the phase ends, against the field value recorded at the edge that started it. The strobe is compared in every cycle against the output transition that the bench observes. The first low phase after enable or reset is measured in edges counted from the release.

// File: rtl/asym_clk_prescaler_pkg.sv
// Package: shared sizing helpers for the asymmetric duty prescaler.
// Assumes: field widths are small positive integers.
package asym_clk_prescaler_pkg;

    // Width of the phase counter: wide enough for the larger field.
    function automatic int cnt_width(input int hi_w, input int lo_w);
        return (hi_w > lo_w) ? hi_w : lo_w;
    endfunction

endpackage

// File: rtl/asym_clk_prescaler_cnt.sv
// Module: phase counter for the prescaler.
// Counts system cycles in the current phase and flags the last cycle of
// the phase. The limit for the next phase is latched from the matching
// field at the phase boundary only, so a running phase is never cut short.
// Assumes: cur_high is the derived clock level of the phase being counted.
module asym_clk_prescaler_cnt #(
    parameter int HI_W  = 5,
    parameter int LO_W  = 3,
    parameter int CNT_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HI_W-1:0] hi_cnt,
    input  logic [LO_W-1:0] lo_cnt,
    input  logic            cur_high,
    output logic            phase_end
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] hi_ext;
    logic [CNT_W-1:0] lo_ext;

    // Zero-extend both fields to the counter width.
    always_comb begin
        hi_ext = CNT_W'(hi_cnt);
        lo_ext = CNT_W'(lo_cnt);
    end

    // Last cycle of the current phase.
    assign phase_end = (cnt_q == lim_q);

    // Phase counter and per-phase limit; a park state always restarts low.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            lim_q <= lo_ext;
        end else if (phase_end) begin
            cnt_q <= '0;
            lim_q <= cur_high ? lo_ext : hi_ext;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/asym_clk_prescaler_out.sv
// Module: output stage for the prescaler.
// Holds the derived clock level, toggling it when the counter signals the
// end of a phase, and registers a one-cycle strobe aligned with each rise.
// Assumes: phase_end is valid every enabled cycle.
module asym_clk_prescaler_out (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic phase_end,
    output logic clk_div,
    output logic rise_stb
);

    // Derived clock level and rise strobe; both parked low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            clk_div  <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            clk_div  <= clk_div ^ phase_end;
            rise_stb <= phase_end & ~clk_div;
        end
    end

endmodule

// File: rtl/asym_clk_prescaler.sv
// Module: asymmetric duty clock prescaler (top).
// Derives a clock whose high and low phases last hi_cnt+1 and lo_cnt+1
// system cycles, plus a strobe on each rising edge of that clock.
// Assumes: a single clock domain; rst_n is synchronous and active low.
module asym_clk_prescaler #(
    parameter int HI_W = 5,
    parameter int LO_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HI_W-1:0] hi_cnt,
    input  logic [LO_W-1:0] lo_cnt,
    output logic            clk_div,
    output logic            rise_stb
);

    localparam int CNT_W = asym_clk_prescaler_pkg::cnt_width(HI_W, LO_W);

    logic phase_end;

    asym_clk_prescaler_cnt #(
        .HI_W  (HI_W),
        .LO_W  (LO_W),
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt),
        .cur_high  (clk_div),
        .phase_end (phase_end)
    );

    asym_clk_prescaler_out out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .phase_end (phase_end),
        .clk_div   (clk_div),
        .rise_stb  (rise_stb)
    );

endmodule

// File: rtl/asym_clk_prescaler_chk.sv
// Module: property checker for the prescaler, bound to the top.
// Tracks phase run lengths and the field values seen at each boundary,
// then checks them against the derived clock and strobe.
// Assumes: bound to asym_clk_prescaler with matching parameters.
module asym_clk_prescaler_chk #(
    parameter int HI_W = 5,
    parameter int LO_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [HI_W-1:0] hi_cnt,
    input logic [LO_W-1:0] lo_cnt,
    input logic            clk_div,
    input logic            rise_stb
);

    localparam int RUN_W = (HI_W > LO_W ? HI_W : LO_W) + 2;

    logic             out_d;
    logic             en_d;
    logic [HI_W-1:0]  hi_d;
    logic [LO_W-1:0]  lo_d;
    logic [HI_W-1:0]  hi_exp;
    logic [LO_W-1:0]  lo_exp;
    logic             lo_valid;
    logic [RUN_W-1:0] run_q;

    // Run length of the level held before this cycle, plus boundary fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_d    <= 1'b0;
            en_d     <= 1'b0;
            hi_d     <= '0;
            lo_d     <= '0;
            hi_exp   <= '0;
            lo_exp   <= '0;
            lo_valid <= 1'b0;
            run_q    <= RUN_W'(1);
        end else begin
            out_d <= clk_div;
            en_d  <= en;
            hi_d  <= hi_cnt;
            lo_d  <= lo_cnt;
            if (clk_div != out_d) begin
                run_q <= RUN_W'(1);
                if (clk_div) hi_exp <= hi_d;
                else         lo_exp <= lo_d;
            end else if (run_q != '1) begin
                run_q <= run_q + RUN_W'(1);
            end
            if (!en)                         lo_valid <= 1'b0;
            else if (out_d && !clk_div)      lo_valid <= en_d;
        end
    end

    // R1: a high phase ended by the counter lasts hi_cnt+1 cycles.
    p_high_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_d && !clk_div && en_d) |-> (run_q == RUN_W'(hi_exp) + RUN_W'(1)));

    // R2: a low phase that followed a high phase lasts lo_cnt+1 cycles.
    p_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_d && clk_div && lo_valid) |-> (run_q == RUN_W'(lo_exp) + RUN_W'(1)));

    // R5: strobe marks exactly the first high cycle.
    p_rise_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb == (clk_div && !out_d));

    // R5: strobe never lasts two cycles.
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);

    // R6: a low enable parks both outputs low on the next cycle.
    p_park_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!clk_div && !rise_stb));

endmodule

bind asym_clk_prescaler asym_clk_prescaler_chk #(
    .HI_W (HI_W),
    .LO_W (LO_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt),
    .clk_div  (clk_div),
    .rise_stb (rise_stb)
);

// File: tb/asym_clk_prescaler_tb_top.sv
// Bench: directed corner cases plus seeded random fields for the prescaler.
module asym_clk_prescaler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HI_W = 5;
    localparam int LO_W = 3;
    localparam int WATCHDOG = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [HI_W-1:0] hi_cnt = '0;
    logic [LO_W-1:0] lo_cnt = '0;
    logic            clk_div;
    logic            rise_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Monitor state.
    logic prev_out = 1'b0;
    int   run_len = 0;
    int   exp_len = 0;
    bit   track_valid = 1'b0;
    int   last_high_len = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asym_clk_prescaler #(.HI_W(HI_W), .LO_W(LO_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .hi_cnt   (hi_cnt),
        .lo_cnt   (lo_cnt),
        .clk_div  (clk_div),
        .rise_stb (rise_stb)
    );

    function automatic int phase_len(input int field);
        return field + 1;
    endfunction

    function automatic int period_len(input int hi, input int lo);
        return phase_len(hi) + phase_len(lo);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: sample at the falling edge, before any new drive.
    task automatic tick();
        @(negedge clk);
        cycles++;
        if (!rst_n || !en) begin
            check(clk_div == 1'b0 && rise_stb == 1'b0, rst_n ? "R6 park" : "R7 reset",
                  int'({clk_div, rise_stb}), 0);
            track_valid = 1'b0;
            run_len = 0;
        end else begin
            check(rise_stb == (clk_div && !prev_out), "R5 strobe", int'(rise_stb),
                  int'(clk_div && !prev_out));
            if (clk_div != prev_out) begin
                if (track_valid)
                    check(run_len == exp_len, prev_out ? "R1 high len" : "R2 low len",
                          run_len, exp_len);
                if (prev_out) last_high_len = run_len;
                run_len = 1;
                exp_len = clk_div ? phase_len(int'(hi_cnt)) : phase_len(int'(lo_cnt));
                track_valid = 1'b1;
            end else begin
                run_len++;
            end
        end
        prev_out = clk_div;
    endtask

    task automatic ticks_to_rise(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!rise_stb && n < 200);
    endtask

    task automatic wait_fall();
        int k = 0;
        do begin
            tick();
            k++;
        end while (!(prev_out == 1'b0 && run_len == 1) && k < 200);
    endtask

    task automatic set_fields(input int hi, input int lo);
        hi_cnt = HI_W'(hi);
        lo_cnt = LO_W'(lo);
    endtask

    // Settle on new fields, then measure one rise-to-rise period.
    task automatic period_check(input int hi, input int lo, input string req);
        int n;
        set_fields(hi, lo);
        ticks_to_rise(n);
        ticks_to_rise(n);
        ticks_to_rise(n);
        check(n == period_len(hi, lo), req, n, period_len(hi, lo));
    endtask

    initial begin
        int n;
        int hold;
        // R7: reset state.
        set_fields(19, 7);
        repeat (3) tick();
        check(clk_div == 1'b0 && rise_stb == 1'b0, "R7 reset outputs", int'(clk_div), 0);
        rst_n = 1'b1;
        en = 1'b1;
        // R7: first rise after release on edge lo+1.
        ticks_to_rise(n);
        check(n == phase_len(7), "R7 first rise", n, phase_len(7));

        // R3: three documented field pairs.
        period_check(19, 7, "R3 19/7 period");
        period_check(11, 7, "R3 11/7 period");
        period_check(7, 7, "R3 7/7 period");
        wait_fall();
        check(last_high_len == 8, "R3 7/7 high", last_high_len, 8);

        // R8: extremes.
        period_check(0, 0, "R8 0/0 period");
        period_check(31, 7, "R8 31/7 period");

        // R4: mid-phase change to the high field.
        set_fields(3, 2);
        ticks_to_rise(n);
        ticks_to_rise(n);
        tick();
        hi_cnt = HI_W'(20);
        wait_fall();
        check(last_high_len == phase_len(3), "R4 old high kept", last_high_len, phase_len(3));
        wait_fall();
        check(last_high_len == phase_len(20), "R4 new high used", last_high_len, phase_len(20));

        // R4: mid-phase change to the low field.
        set_fields(2, 6);
        ticks_to_rise(n);
        wait_fall();
        tick();
        lo_cnt = LO_W'(1);
        ticks_to_rise(n);
        check(n == phase_len(6) - 1, "R4 old low kept", n, phase_len(6) - 1);

        // R6: drop enable during a high phase, then resume.
        set_fields(9, 5);
        ticks_to_rise(n);
        ticks_to_rise(n);
        tick();
        en = 1'b0;
        tick();
        check(clk_div == 1'b0, "R6 parked", int'(clk_div), 0);
        tick();
        en = 1'b1;
        ticks_to_rise(n);
        check(n == phase_len(5), "R6 first rise", n, phase_len(5));

        // Random fields and holds; the monitor checks R1, R2, R5, R6.
        void'($urandom(32'h5a17));
        for (int i = 0; i < 400; i++) begin
            set_fields(int'($urandom_range(0, 31)), int'($urandom_range(0, 7)));
            if ($urandom_range(0, 15) == 0) en = 1'b0;
            hold = int'($urandom_range(1, 60));
            for (int j = 0; j < hold; j++) tick();
            en = 1'b1;
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int w = 0; w < WATCHDOG; w++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule